// File: doc/BRIEF.md
# I2C Bus-Clear Recovery Sequencer

This block frees an I2C bus that a slave holds low after an interrupted transfer. When the host controller reports that the bus is still active, or that its transmit holding register stays full, a start request hands both open-drain pins to the sequencer. The sequencer then clocks the bus by hand. Each round pulls SCL low, then SDA low, releases SCL and waits for it to rise, then releases SDA. A slave that stretches the clock gets first a short grace period and then a long one. The loop stops as soon as SDA reads high and SCL was seen high in the round before. It stops in any case after a fixed maximum number of rounds.

After the loop the pins go back to the controller. The block waits a settling time and then samples the controller's bus-active flag once more to decide between success and still-busy. A one-cycle done pulse carries the result and the number of SCL pulses issued. While the sequencer runs, the controller's interrupt is masked. During the hand-clocking phase the controller's own pin drives are replaced by the sequencer's. All delays are parameters in system-clock cycles.

Top module: `i2c_bus_unjam`

## Requirements
- R1: A start while neither bus-active nor tx-full is set produces done_o on the cycle after the start edge, with ok_o=1 and pulses_o=0, and drives no pin low.
- R2: At most MAX_PULSES (default 9) rounds run. If the bus never frees, exactly MAX_PULSES SCL pulses are issued, and each pulse is one rising edge of scl_oe_o.
- R3: A round is one cycle of the loop check, then STEP_CYC cycles with scl_oe_o=1 and sda_oe_o=0, then STEP_CYC cycles with both at 1, then STEP_CYC cycles with scl_oe_o=0 and sda_oe_o=1, after which SCL is sampled. It ends with STEP_CYC cycles with both at 0.
- R4: If SCL is still low when sampled, the sequencer waits SHORT_CYC more cycles and samples again. SCL high at that point counts as seen high.
- R5: If SCL is still low after the short wait, the sequencer waits LONG_CYC cycles, and the SCL level at the end becomes the round's seen-high flag.
- R6: Before each round after the first, the loop ends if SDA is high and SCL was seen high in the previous round. pulses_o then equals the number of rounds done.
- R7: After the loop, pin control returns to the controller for SETTLE_CYC cycles. ok_o is then set to the inverse of bus_active_i.
- R8: done_o lasts one cycle, and ok_o and pulses_o hold their value until the next accepted start. A start while busy_o=1 is ignored.
- R9: While busy_o=1, irq_o=0. From the start edge until the loop ends, the controller's pin drives are ignored. While idle, scl_oe_o, sda_oe_o and irq_o follow the controller.
- R10: tx_full_i alone, with bus_active_i low, is enough to run the recovery loop.
- R11: After reset busy_o=0, done_o=0, ok_o=0 and pulses_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Recovery request pulse |
| bus_active_i | input | 1 | Controller reports bus busy |
| tx_full_i | input | 1 | Controller transmit holding register full |
| ctl_scl_oe_i | input | 1 | Controller pulls SCL low |
| ctl_sda_oe_i | input | 1 | Controller pulls SDA low |
| ctl_irq_i | input | 1 | Controller interrupt |
| scl_in_i | input | 1 | Sensed SCL level |
| sda_in_i | input | 1 | Sensed SDA level |
| scl_oe_o | output | 1 | Pull SCL pad low |
| sda_oe_o | output | 1 | Pull SDA pad low |
| irq_o | output | 1 | Interrupt after masking |
| busy_o | output | 1 | Sequencer active |
| done_o | output | 1 | One-cycle completion pulse |
| ok_o | output | 1 | Bus idle after recovery |
| pulses_o | output | $clog2(MAX_PULSES+1) | SCL pulses issued |

## Verification
A wrong round counter shows up at once as a mismatch between pulses_o and the number of scl_oe_o rising edges. It can also show as a tenth pulse on a bus that never frees. A lost seen-high flag or a broken early-exit test makes a freed bus run to the full pulse count, which is visible at done. Wrong stretch handling is seen within one round: the run ends too soon for the long grace period, or it fails to exit when the slave releases during that period. Mux or masking faults appear on the first cycle after the start edge, because a controller drive or interrupt leaks onto the pins.

// File: rtl/i2c_unjam_pkg.sv
package i2c_unjam_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LOOP,
        ST_SCL_LO,
        ST_SDA_LO,
        ST_SCL_REL,
        ST_WAIT_SHORT,
        ST_WAIT_LONG,
        ST_SDA_REL,
        ST_SETTLE,
        ST_DONE
    } unjam_state_e;

    typedef struct packed {
        logic own;
        logic scl_low;
        logic sda_low;
    } pin_ctl_t;

endpackage

// File: rtl/unjam_timer.sv
module unjam_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/unjam_pin_mux.sv
module unjam_pin_mux
    import i2c_unjam_pkg::*;
(
    input  pin_ctl_t seq,
    input  logic     busy,
    input  logic     ctl_scl_oe,
    input  logic     ctl_sda_oe,
    input  logic     ctl_irq,
    output logic     scl_oe,
    output logic     sda_oe,
    output logic     irq
);
    always_comb begin
        if (seq.own) begin
            scl_oe = seq.scl_low;
            sda_oe = seq.sda_low;
        end else begin
            scl_oe = ctl_scl_oe;
            sda_oe = ctl_sda_oe;
        end
        irq = ctl_irq & ~busy;
    end
endmodule

// File: rtl/i2c_bus_unjam.sv
module i2c_bus_unjam
    import i2c_unjam_pkg::*;
#(
    parameter int MAX_PULSES = 9,
    parameter int STEP_CYC   = 500,
    parameter int SHORT_CYC  = 2500,
    parameter int LONG_CYC   = 1000000,
    parameter int SETTLE_CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic bus_active_i,
    input  logic tx_full_i,
    input  logic ctl_scl_oe_i,
    input  logic ctl_sda_oe_i,
    input  logic ctl_irq_i,
    input  logic scl_in_i,
    input  logic sda_in_i,
    output logic scl_oe_o,
    output logic sda_oe_o,
    output logic irq_o,
    output logic busy_o,
    output logic done_o,
    output logic ok_o,
    output logic [$clog2(MAX_PULSES+1)-1:0] pulses_o
);
    localparam int CW    = $clog2(MAX_PULSES + 1);
    localparam int MAX_A = (STEP_CYC > SHORT_CYC) ? STEP_CYC : SHORT_CYC;
    localparam int MAX_B = (LONG_CYC > SETTLE_CYC) ? LONG_CYC : SETTLE_CYC;
    localparam int MAXD  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int TW    = $clog2(MAXD + 1);

    localparam logic [TW-1:0] STEP_LD   = TW'(STEP_CYC - 1);
    localparam logic [TW-1:0] SHORT_LD  = TW'(SHORT_CYC - 1);
    localparam logic [TW-1:0] LONG_LD   = TW'(LONG_CYC - 1);
    localparam logic [TW-1:0] SETTLE_LD = TW'(SETTLE_CYC - 1);

    typedef struct packed {
        unjam_state_e     st;
        logic [CW-1:0]    cnt;
        logic             seen;
        logic             ok;
    } core_t;

    core_t core_d, core_q;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_zero;
    pin_ctl_t      pins;

    unjam_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    // next-state logic
    always_comb begin
        core_d   = core_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (core_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    core_d.cnt  = '0;
                    core_d.seen = 1'b0;
                    if (bus_active_i || tx_full_i) begin
                        core_d.st = ST_LOOP;
                        core_d.ok = 1'b0;
                    end else begin
                        core_d.st = ST_DONE;
                        core_d.ok = 1'b1;
                    end
                end
            end
            ST_LOOP: begin
                if ((sda_in_i && core_q.seen) || core_q.cnt == CW'(MAX_PULSES)) begin
                    core_d.st = ST_SETTLE;
                    tmr_load  = 1'b1;
                    tmr_val   = SETTLE_LD;
                end else begin
                    core_d.cnt  = core_q.cnt + 1'b1;
                    core_d.seen = 1'b0;
                    core_d.st   = ST_SCL_LO;
                    tmr_load    = 1'b1;
                    tmr_val     = STEP_LD;
                end
            end
            ST_SCL_LO: begin
                if (tmr_zero) begin
                    core_d.st = ST_SDA_LO;
                    tmr_load  = 1'b1;
                    tmr_val   = STEP_LD;
                end
            end
            ST_SDA_LO: begin
                if (tmr_zero) begin
                    core_d.st = ST_SCL_REL;
                    tmr_load  = 1'b1;
                    tmr_val   = STEP_LD;
                end
            end
            ST_SCL_REL: begin
                if (tmr_zero) begin
                    tmr_load = 1'b1;
                    if (scl_in_i) begin
                        core_d.seen = 1'b1;
                        core_d.st   = ST_SDA_REL;
                        tmr_val     = STEP_LD;
                    end else begin
                        core_d.st = ST_WAIT_SHORT;
                        tmr_val   = SHORT_LD;
                    end
                end
            end
            ST_WAIT_SHORT: begin
                if (tmr_zero) begin
                    tmr_load = 1'b1;
                    if (scl_in_i) begin
                        core_d.seen = 1'b1;
                        core_d.st   = ST_SDA_REL;
                        tmr_val     = STEP_LD;
                    end else begin
                        core_d.st = ST_WAIT_LONG;
                        tmr_val   = LONG_LD;
                    end
                end
            end
            ST_WAIT_LONG: begin
                if (tmr_zero) begin
                    core_d.seen = scl_in_i;
                    core_d.st   = ST_SDA_REL;
                    tmr_load    = 1'b1;
                    tmr_val     = STEP_LD;
                end
            end
            ST_SDA_REL: begin
                if (tmr_zero) core_d.st = ST_LOOP;
            end
            ST_SETTLE: begin
                if (tmr_zero) begin
                    core_d.ok = ~bus_active_i;
                    core_d.st = ST_DONE;
                end
            end
            ST_DONE: core_d.st = ST_IDLE;
            default: core_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q.st   <= ST_IDLE;
            core_q.cnt  <= '0;
            core_q.seen <= 1'b0;
            core_q.ok   <= 1'b0;
        end else begin
            core_q <= core_d;
        end
    end

    // pin ownership decoded from the current phase
    always_comb begin
        pins.own     = 1'b0;
        pins.scl_low = 1'b0;
        pins.sda_low = 1'b0;
        unique case (core_q.st)
            ST_LOOP, ST_SDA_REL:  pins.own = 1'b1;
            ST_SCL_LO: begin
                pins.own     = 1'b1;
                pins.scl_low = 1'b1;
            end
            ST_SDA_LO: begin
                pins.own     = 1'b1;
                pins.scl_low = 1'b1;
                pins.sda_low = 1'b1;
            end
            ST_SCL_REL, ST_WAIT_SHORT, ST_WAIT_LONG: begin
                pins.own     = 1'b1;
                pins.sda_low = 1'b1;
            end
            default: ;
        endcase
    end

    assign busy_o   = (core_q.st != ST_IDLE);
    assign done_o   = (core_q.st == ST_DONE);
    assign ok_o     = core_q.ok;
    assign pulses_o = core_q.cnt;

    unjam_pin_mux u_mux (
        .seq        (pins),
        .busy       (busy_o),
        .ctl_scl_oe (ctl_scl_oe_i),
        .ctl_sda_oe (ctl_sda_oe_i),
        .ctl_irq    (ctl_irq_i),
        .scl_oe     (scl_oe_o),
        .sda_oe     (sda_oe_o),
        .irq        (irq_o)
    );

    // R2
    pulse_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulses_o <= CW'(MAX_PULSES));

    // R2
    pulse_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (pulses_o == $past(pulses_o)) || (pulses_o == $past(pulses_o) + 1'b1) || !$past(busy_o) || (pulses_o == '0));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o && start_i) |=> busy_o);

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> ($stable(ok_o) && $stable(pulses_o)));

    // R9
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !irq_o);

    // R9
    idle_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (scl_oe_o == ctl_scl_oe_i && sda_oe_o == ctl_sda_oe_i && irq_o == ctl_irq_i));
endmodule

// File: tb/i2c_bus_unjam_test.sv
module i2c_bus_unjam_test;
    localparam int MAXP = 9;
    localparam int STEP = 8;
    localparam int SHRT = 20;
    localparam int LNG  = 100;
    localparam int STL  = 6;
    localparam int CW   = $clog2(MAXP + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic bus_active_i, tx_full_i;
    logic ctl_scl_oe_i = 1'b0, ctl_sda_oe_i = 1'b0, ctl_irq_i = 1'b0;
    logic scl_in_i, sda_in_i;
    logic scl_oe_o, sda_oe_o, irq_o, busy_o, done_o, ok_o;
    logic [CW-1:0] pulses_o;

    always #5 clk = ~clk;

    i2c_bus_unjam #(.MAX_PULSES(MAXP), .STEP_CYC(STEP), .SHORT_CYC(SHRT),
                    .LONG_CYC(LNG), .SETTLE_CYC(STL)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .bus_active_i(bus_active_i), .tx_full_i(tx_full_i),
        .ctl_scl_oe_i(ctl_scl_oe_i), .ctl_sda_oe_i(ctl_sda_oe_i),
        .ctl_irq_i(ctl_irq_i), .scl_in_i(scl_in_i), .sda_in_i(sda_in_i),
        .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o), .irq_o(irq_o),
        .busy_o(busy_o), .done_o(done_o), .ok_o(ok_o), .pulses_o(pulses_o));

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int done_cyc = 0;
    bit finished = 0;

    // slave / bus model
    int  sl_k = 0;
    int  sl_stretch = 0;
    int  hold_cnt = 0;
    int  edges = 0;
    int  oe_rise = 0;
    bit  sda_hold = 0;
    bit  extra_busy = 0;
    bit  wfull = 0;
    bit  prev_oe = 0;
    bit  prev_line = 1;

    assign scl_in_i     = !(scl_oe_o || hold_cnt != 0);
    assign sda_in_i     = !(sda_oe_o || sda_hold);
    assign bus_active_i = sda_hold || extra_busy;
    assign tx_full_i    = wfull;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        bit line;
        if (prev_oe && !scl_oe_o) hold_cnt = sl_stretch;
        else if (hold_cnt > 0)    hold_cnt = hold_cnt - 1;
        if (scl_oe_o && !prev_oe) oe_rise = oe_rise + 1;
        line = !(scl_oe_o || hold_cnt != 0);
        if (line && !prev_line) edges = edges + 1;
        if (edges >= sl_k) sda_hold = 0;
        prev_oe = scl_oe_o;
        prev_line = line;
    end

    typedef struct {
        int  pulses;
        bit  ok;
        string tag;
    } exp_t;
    exp_t sb[$];

    task automatic check(input bit cond, input string tag, input int act, input int expv);
        total++;
        if (!cond) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // monitor: compares each result against the scoreboard
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            done_cyc = cyc;
            if (sb.size() == 0) begin
                check(0, "R8 unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(int'(pulses_o) == e.pulses, {e.tag, " pulses"}, int'(pulses_o), e.pulses);
                check(ok_o == e.ok, {e.tag, " ok"}, int'(ok_o), int'(e.ok));
                check(int'(pulses_o) == oe_rise, "R2 pulses vs scl_oe edges", int'(pulses_o), oe_rise);
            end
        end
    end

    task automatic run_case(input int k, input int s, input bit eb, input bit wf,
                            input int ep, input bit eo, input string tag,
                            input bit quick, input bit extra_start, input bit probe,
                            input int min_len);
        exp_t e;
        int t0;
        @(negedge clk);
        #1;
        sl_k = k; sl_stretch = s; extra_busy = eb; wfull = wf;
        edges = 0; hold_cnt = 0; oe_rise = 0; sda_hold = (k > 0);
        prev_line = 1;
        if (probe) begin ctl_sda_oe_i = 1'b1; ctl_irq_i = 1'b1; end
        e.pulses = ep; e.ok = eo; e.tag = tag;
        sb.push_back(e);
        start_i = 1'b1;
        t0 = cyc;
        @(negedge clk);
        start_i = 1'b0;
        if (quick) begin
            // R1
            check(done_o == 1'b1, "R1 done one cycle after start", int'(done_o), 1);
            check(scl_oe_o == 1'b0 && sda_oe_o == 1'b0, "R1 no pin driven", int'({scl_oe_o, sda_oe_o}), 0);
        end
        if (probe) begin
            // R9
            check(irq_o == 1'b0, "R9 irq masked", int'(irq_o), 0);
            check(sda_oe_o == 1'b0, "R9 controller drive overridden", int'(sda_oe_o), 0);
            @(negedge clk);
            // R3
            check(scl_oe_o && !sda_oe_o, "R3 phase scl low", int'({scl_oe_o, sda_oe_o}), 2);
            repeat (STEP) @(negedge clk);
            check(scl_oe_o && sda_oe_o, "R3 phase both low", int'({scl_oe_o, sda_oe_o}), 3);
            repeat (STEP) @(negedge clk);
            check(!scl_oe_o && sda_oe_o, "R3 phase scl released", int'({scl_oe_o, sda_oe_o}), 1);
        end
        if (extra_start) begin
            repeat (30) @(negedge clk);
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        while (busy_o) @(negedge clk);
        if (probe) begin ctl_sda_oe_i = 1'b0; ctl_irq_i = 1'b0; end
        if (min_len > 0)
            check(done_cyc - t0 >= min_len, "R5 long wait duration", done_cyc - t0, min_len);
        repeat (3) @(negedge clk);
        // R8
        check(int'(pulses_o) == ep && done_o == 1'b0, "R8 result held", int'(pulses_o), ep);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11
        check(!busy_o && !done_o && !ok_o && pulses_o == '0, "R11 reset state",
              int'({busy_o, done_o, ok_o}), 0);
        ctl_scl_oe_i = 1'b1; ctl_irq_i = 1'b1;
        #1;
        // R9 idle passthrough
        check(scl_oe_o && irq_o, "R9 idle follows controller", int'({scl_oe_o, irq_o}), 3);
        ctl_scl_oe_i = 1'b0; ctl_irq_i = 1'b0;

        run_case(0, 0, 0, 0, 0, 1, "R1 not stuck", 1, 0, 0, 0);
        run_case(3, 0, 0, 0, 3, 1, "R6 early exit k3", 0, 0, 0, 0);
        run_case(1, 0, 0, 0, 1, 1, "R6 early exit k1", 0, 0, 0, 0);
        run_case(0, 0, 1, 0, 1, 0, "R7 still busy", 0, 0, 0, 0);
        run_case(0, 0, 0, 1, 1, 1, "R10 tx full only", 0, 0, 0, 0);
        run_case(20, 0, 0, 0, MAXP, 0, "R2 never frees", 0, 0, 0, 0);
        run_case(2, 12, 0, 0, 2, 1, "R4 short stretch", 0, 0, 0, 0);
        run_case(2, 50, 0, 0, 2, 1, "R5 long stretch", 0, 0, 0, 2 * (3 * STEP + SHRT + LNG));
        run_case(2, 200, 0, 0, MAXP, 0, "R5 stretch too long", 0, 0, 0, 0);
        run_case(3, 0, 0, 0, 3, 1, "R8 start while busy", 0, 1, 0, 0);
        run_case(3, 0, 0, 0, 3, 1, "R9 R3 probe run", 0, 0, 1, 0);

        check(sb.size() == 0, "R8 all results seen", sb.size(), 0);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule